// File: doc/BRIEF.md
# Channel Enable and Event Interrupt Register Bank

This block is the shared register bank of a multi-channel pulse-width modulator. It keeps one run-enable bit for each channel and drives those bits out to the channel counters. It keeps an interrupt mask bit and a latched end-of-period event bit for each channel, and it combines them into one interrupt request line.

Software never writes the enable or mask state directly. Each has a pair of registers: a write of ones to one register sets the chosen bits, and a write of ones to the other clears them. Zero bits in the written data leave the state alone, so one channel can be changed without first reading the others.

The event bits are read-to-clear. A read of the event register returns the latched events and acknowledges them on the same clock edge. An event that arrives in the cycle of that read is kept and is not lost. The bus data width equals the channel count, and bit n of every register refers to channel n.

Top module: `chan_gate_irq`

## Requirements
- R1: After reset, every enable bit, mask bit and latched event bit is 0, and `irqReq` is 0.
- R2: A write to byte offset 0x04 sets each `chanRun` bit whose data bit is 1. The change is visible after the write's clock edge, and data bits that are 0 leave their channel unchanged.
- R3: A write to offset 0x08 clears each `chanRun` bit whose data bit is 1, and data bits that are 0 leave their channel unchanged.
- R4: A read of offset 0x0C returns the current enable bits, with bit n standing for channel n. A write to 0x0C changes nothing.
- R5: A write of ones to offset 0x10 sets mask bits, and a write of ones to offset 0x14 clears them. A read of offset 0x18 returns the mask, and a write to 0x18 changes nothing.
- R6: A one-cycle pulse on `periodEvt[n]` latches event bit n whether or not the channel is masked. A read of offset 0x1C returns the latched bits and clears them at the clock edge that ends the read.
- R7: An event that arrives in the same cycle as a read of 0x1C is not returned by that read and stays latched afterwards.
- R8: `irqReq` is 1 exactly when some channel has its latched event bit and its mask bit both at 1. It rises in the cycle after the event edge and falls after the clearing read.
- R9: Offset 0x00 and any access whose `busAddr[1:0]` is not 0 read as zero and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | NCH | Write data, bit n is channel n |
| busRdata | output | NCH | Read data, valid in the cycle of the access |
| periodEvt | input | NCH | Per-channel end-of-period pulse |
| chanRun | output | NCH | Per-channel run enable |
| irqReq | output | 1 | Combined interrupt request |

## Verification
The assertions check four things every cycle:
- A set write leaves all of its chosen bits at 1.
- A clear write leaves all of its chosen bits at 0.
- The enables hold steady when neither enable register is written.
- Every incoming event is latched, including one that arrives during a clearing read.

A further assertion checks that a read with no incoming events drops the interrupt line. The bench scenarios show the rest:
- the exact values read back at each offset;
- that writes to the read-only offsets, to offset 0x00 and to misaligned offsets have no effect;
- that masked-off events are latched but raise no interrupt;
- that an event arriving during the clearing read appears on the next read.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;
  // Word index of each register (byte offset / 4)
  localparam logic [2:0] IDX_MODE  = 3'd0;
  localparam logic [2:0] IDX_RUNSET = 3'd1;
  localparam logic [2:0] IDX_RUNCLR = 3'd2;
  localparam logic [2:0] IDX_RUNSTS = 3'd3;
  localparam logic [2:0] IDX_MSKSET = 3'd4;
  localparam logic [2:0] IDX_MSKCLR = 3'd5;
  localparam logic [2:0] IDX_MSKVAL = 3'd6;
  localparam logic [2:0] IDX_EVTSTS = 3'd7;

  typedef struct packed {
    logic       runSet;
    logic       runClr;
    logic       mskSet;
    logic       mskClr;
    logic       evtAck;
    logic       rdValid;
    logic [2:0] rdIdx;
  } gate_strobe_t;
endpackage

// File: rtl/chan_gate_ctrl.sv
module chan_gate_ctrl
  import chan_gate_pkg::*;
(
  input  logic         busSel,
  input  logic         busWr,
  input  logic [4:0]   busAddr,
  output gate_strobe_t strb
);
  logic       aligned;
  logic       doWr;
  logic       doRd;
  logic [2:0] wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[4:2];
  assign doWr    = busSel && busWr && aligned;
  assign doRd    = busSel && !busWr && aligned;

  always_comb begin
    strb         = '0;
    strb.rdValid = doRd;
    strb.rdIdx   = wordIdx;
    if (doWr) begin
      unique case (wordIdx)
        IDX_RUNSET: strb.runSet = 1'b1;
        IDX_RUNCLR: strb.runClr = 1'b1;
        IDX_MSKSET: strb.mskSet = 1'b1;
        IDX_MSKCLR: strb.mskClr = 1'b1;
        default:    ;
      endcase
    end
    if (doRd && wordIdx == IDX_EVTSTS) strb.evtAck = 1'b1;
  end
endmodule

// File: rtl/chan_gate_dp.sv
module chan_gate_dp
  import chan_gate_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  gate_strobe_t   strb,
  input  logic [NCH-1:0] wBits,
  input  logic [NCH-1:0] periodEvt,
  output logic [NCH-1:0] rdData,
  output logic [NCH-1:0] runBits,
  output logic           irqReq
);
  logic [NCH-1:0] runQ, mskQ, evtQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= '0;
      mskQ <= '0;
      evtQ <= '0;
    end else begin
      if (strb.runSet)      runQ <= runQ | wBits;
      else if (strb.runClr) runQ <= runQ & ~wBits;
      if (strb.mskSet)      mskQ <= mskQ | wBits;
      else if (strb.mskClr) mskQ <= mskQ & ~wBits;
      evtQ <= (strb.evtAck ? '0 : evtQ) | periodEvt;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdValid) begin
      unique case (strb.rdIdx)
        IDX_RUNSTS: rdData = runQ;
        IDX_MSKVAL: rdData = mskQ;
        IDX_EVTSTS: rdData = evtQ;
        default:    rdData = '0;
      endcase
    end
  end

  assign runBits = runQ;
  assign irqReq  = |(evtQ & mskQ);

  // R2
  run_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.runSet |=> ((runBits & $past(wBits)) == $past(wBits)));
  // R3
  run_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.runClr |=> ((runBits & $past(wBits)) == '0));
  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runSet && !strb.runClr) |=> $stable(runBits));
  // R7
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodEvt != '0) |=> ((evtQ & $past(periodEvt)) == $past(periodEvt)));
  // R8
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtAck && periodEvt == '0) |=> !irqReq);
endmodule

// File: rtl/chan_gate_irq.sv
module chan_gate_irq
  import chan_gate_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busSel,
  input  logic           busWr,
  input  logic [4:0]     busAddr,
  input  logic [NCH-1:0] busWdata,
  output logic [NCH-1:0] busRdata,
  input  logic [NCH-1:0] periodEvt,
  output logic [NCH-1:0] chanRun,
  output logic           irqReq
);
  gate_strobe_t strb;

  chan_gate_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  chan_gate_dp #(.NCH(NCH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wBits    (busWdata),
    .periodEvt(periodEvt),
    .rdData   (busRdata),
    .runBits  (chanRun),
    .irqReq   (irqReq)
  );
endmodule

// File: tb/test_chan_gate_irq.sv
module test_chan_gate_irq;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busSel = 1'b0;
  logic           busWr = 1'b0;
  logic [4:0]     busAddr = '0;
  logic [NCH-1:0] busWdata = '0;
  logic [NCH-1:0] busRdata;
  logic [NCH-1:0] periodEvt = '0;
  logic [NCH-1:0] chanRun;
  logic           irqReq;

  int checks = 0;
  int fails  = 0;
  logic [NCH-1:0] expQ[$];
  string          tagQ[$];

  always #10 clk = ~clk;

  chan_gate_irq #(.NCH(NCH)) i_chan_gate_irq (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .periodEvt(periodEvt), .chanRun(chanRun), .irqReq(irqReq)
  );

  // Monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (busSel && !busWr) begin
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: act %h exp none", busRdata);
      end else begin
        logic [NCH-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (busRdata !== e) begin
          fails++;
          $display("FAIL %s read: act %h exp %h", t, busRdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #2;
    busSel = 1'b0; busWr = 1'b0; periodEvt = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [NCH-1:0] d);
    @(posedge clk); #2;
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    idle();
  endtask

  task automatic rd(input logic [4:0] a, input logic [NCH-1:0] e,
                    input string t, input logic [NCH-1:0] ev = '0);
    @(posedge clk); #2;
    busSel = 1'b1; busWr = 1'b0; busAddr = a; periodEvt = ev;
    expQ.push_back(e); tagQ.push_back(t);
    idle();
  endtask

  task automatic pulse(input logic [NCH-1:0] ev);
    @(posedge clk); #2;
    periodEvt = ev;
    idle();
  endtask

  task automatic chkOut(input logic [NCH-1:0] eRun, input logic eIrq,
                        input string t);
    @(negedge clk);
    checks++;
    if (chanRun !== eRun || irqReq !== eIrq) begin
      fails++;
      $display("FAIL %s: act run=%h irq=%b exp run=%h irq=%b",
               t, chanRun, irqReq, eRun, eIrq);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act hung exp done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    chkOut(4'h0, 1'b0, "R1 outputs");
    rd(5'h0C, 4'h0, "R1 run status");
    rd(5'h18, 4'h0, "R1 mask");
    rd(5'h1C, 4'h0, "R1 events");

    wr(5'h04, 4'h5); chkOut(4'h5, 1'b0, "R2 set 5");
    wr(5'h04, 4'h0); chkOut(4'h5, 1'b0, "R2 zero bits");
    wr(5'h04, 4'h2); chkOut(4'h7, 1'b0, "R2 set 2");
    wr(5'h08, 4'h4); chkOut(4'h3, 1'b0, "R3 clear 4");
    wr(5'h08, 4'h0); chkOut(4'h3, 1'b0, "R3 zero bits");
    rd(5'h0C, 4'h3, "R4 run status");
    wr(5'h0C, 4'hF); chkOut(4'h3, 1'b0, "R4 status write ignored");
    wr(5'h00, 4'hF); chkOut(4'h3, 1'b0, "R9 mode write ignored");
    rd(5'h00, 4'h0, "R9 mode read");
    wr(5'h05, 4'hC); chkOut(4'h3, 1'b0, "R9 misaligned write");
    rd(5'h0D, 4'h0, "R9 misaligned read");

    wr(5'h10, 4'h9); rd(5'h18, 4'h9, "R5 mask set");
    wr(5'h18, 4'h6); rd(5'h18, 4'h9, "R5 mask write ignored");
    wr(5'h14, 4'h8); rd(5'h18, 4'h1, "R5 mask clear");

    pulse(4'h2); chkOut(4'h3, 1'b0, "R8 masked event no irq");
    rd(5'h1C, 4'h2, "R6 event latched");
    rd(5'h1C, 4'h0, "R6 cleared by read");
    pulse(4'h1); chkOut(4'h3, 1'b1, "R8 irq raised");
    rd(5'h1C, 4'h1, "R7 read with new event", 4'h4);
    chkOut(4'h3, 1'b0, "R8 irq cleared");
    rd(5'h1C, 4'h4, "R7 event kept");
    rd(5'h1C, 4'h0, "R6 empty after read");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R6 scoreboard: act %0d pending exp 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule